// File: doc/BRIEF.md
# Duplex Channel Failover Controller

This block supervises a pair of identical processing channels, A (index 0) and B (index 1). One channel is active and drives the block's output. The other is a spare. For every input sample, the block receives the sample itself and each channel's result word and valid flag. From these it decides whether the active result can be forwarded, and whether a channel has to be marked faulty.

A sample is examined only if it lies inside a configured inclusive range. For an examined sample, the block looks at three things: whether each channel's valid flag is set, and whether the two results agree. This first indication names a suspect channel. When confirmation is switched on, a pass/fail diagnostic is run on the suspect before any decision is taken. If the suspect passes, the diagnostic is run on the other channel. A confirmed fault on the active channel moves selection to the healthy channel, in either direction. The sample in flight at that moment is dropped and flagged as lost. Fault marks and the dual-fault alarm stay set until a clear pulse, so the selection cannot oscillate.

A 2-bit sparing mode controls how the spare is powered and when its result is trusted. Hot and the reserved code keep the spare running and always trusted. Warm keeps it running but trusts it only while its ready flag is high. Cold keeps it off until an isolation is in progress.

Top module: `dup_failover`

## Requirements
- R1: After reset, channel A (sel_o = 0) is active, and fault_o, alarm_o, out_valid_o, lost_o and diag_req_o are all 0.
- R2: A sample is examined when smp_vld_i is high. If both channels' results are valid and equal (or the spare is untrusted), the active result appears on out_data_o with out_valid_o high one clock later.
- R3: A sample outside the inclusive range lo_i..hi_i is ignored. It produces no output, changes no fault mark and does not move the selection.
- R4: With confirmation off, the active channel is marked faulty when its valid flag is low, or when a trusted spare reports a different result. Selection then moves to the other channel, lost_o is high for exactly one cycle, and out_valid_o stays low for that sample.
- R5: Failover works in both directions: from A to B and, after a clear, from B back to A.
- R6: With confirmation off, a trusted spare whose valid flag is low is marked faulty. The active result is still forwarded and the selection is unchanged.
- R7: The spare is trusted in mode 2'b00 (hot) and in mode 2'b11 (reserved, treated as hot). In mode 2'b01 (warm) and mode 2'b10 (cold) it is trusted only while its rdy flag is high. A channel marked faulty is never trusted. An untrusted spare's result or valid flag never leads to a fault mark or a failover.
- R8: The active channel's enable output is always high. The spare's enable is high in hot, warm and reserved modes. In cold mode it is high only while an isolation diagnostic is in progress. A spare that is marked faulty has its enable low.
- R9: With confirmation on, a suspect raises diag_req_o with diag_ch_o naming the suspect. If diag_done_i arrives with diag_pass_i low, the suspect is marked faulty (applying R4/R6). If it arrives with diag_pass_i high, the other channel is diagnosed next.
- R10: The sticky alarm_o is raised in three cases: both channels fail the valid check while the spare is trusted, both diagnostics pass, or the active channel faults while the spare is already marked faulty. While the alarm is set, the selection holds and out_valid_o stays low.
- R11: Fault marks stay set until a clear_i pulse. The clear pulse resets the fault marks and the alarm but leaves the selection unchanged.
- R12: Samples that arrive while a diagnostic is in progress produce no output and no fault decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Sparing mode: 00 hot, 01 warm, 10 cold, 11 hot |
| confirm_i | input | 1 | Require a diagnostic before marking a channel |
| clear_i | input | 1 | Pulse that clears the fault marks and the alarm |
| lo_i | input | W | Lower bound of the accepted sample range |
| hi_i | input | W | Upper bound of the accepted sample range |
| smp_i | input | W | Input sample both channels worked on |
| smp_vld_i | input | 1 | Sample and results present this cycle |
| res_a_i | input | W | Channel A result |
| vld_a_i | input | 1 | Channel A result valid |
| rdy_a_i | input | 1 | Channel A ready (trusted as spare) |
| res_b_i | input | W | Channel B result |
| vld_b_i | input | 1 | Channel B result valid |
| rdy_b_i | input | 1 | Channel B ready (trusted as spare) |
| diag_done_i | input | 1 | Diagnostic finished |
| diag_pass_i | input | 1 | Diagnostic verdict, 1 = channel healthy |
| en_a_o | output | 1 | Channel A enable |
| en_b_o | output | 1 | Channel B enable |
| diag_req_o | output | 1 | Diagnostic requested |
| diag_ch_o | output | 1 | Channel under diagnostic (0 = A) |
| out_data_o | output | W | Forwarded result |
| out_valid_o | output | 1 | Forwarded result valid |
| sel_o | output | 1 | Active channel (0 = A) |
| lost_o | output | 1 | Sample dropped at switchover |
| fault_o | output | 2 | Fault marks, bit 0 = A, bit 1 = B |
| alarm_o | output | 1 | Sticky dual-fault alarm |

## Verification
A wrong selection or fault mark shows up at the ports one clock after the deciding sample. sel_o, fault_o and the enables then disagree with the expected state, and every later sample is forwarded from the wrong channel, so an error spreads through the rest of a sweep instead of staying hidden. Trust and mode errors appear as spurious or missing failovers on the very sample that carries a mismatch. Diagnostic sequencing errors appear as diag_req_o or diag_ch_o being wrong one cycle after the suspect sample, or after the diag_done_i cycle.

// File: rtl/dup_failover_pkg.sv
package dup_failover_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_HOT  = 2'b00,
    MODE_WARM = 2'b01,
    MODE_COLD = 2'b10,
    MODE_RSVD = 2'b11
  } spare_mode_e;

  typedef enum logic [1:0] {
    V_OK,
    V_SUSP_ACT,
    V_SUSP_SB,
    V_BOTH
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIAG1,
    ST_DIAG2
  } iso_state_e;
endpackage

// File: rtl/dfo_classify.sv
module dfo_classify
  import dup_failover_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]          smp_i,
  input  logic [W-1:0]          lo_i,
  input  logic [W-1:0]          hi_i,
  input  logic [NCH-1:0][W-1:0] res_i,
  input  logic [NCH-1:0]        vld_i,
  input  logic [NCH-1:0]        rdy_i,
  input  logic [NCH-1:0]        fault_i,
  input  logic                  sel_i,
  input  logic [1:0]            mode_i,
  output logic                  in_ok_o,
  output verdict_e              verdict_o,
  output logic [W-1:0]          act_res_o
);
  logic           hot;
  logic [NCH-1:0] trust;
  logic           sb, a_ok, s_ok, s_tr, mism;

  assign hot = (mode_i == MODE_HOT) || (mode_i == MODE_RSVD);

  for (genvar c = 0; c < NCH; c++) begin : g_trust
    assign trust[c] = !fault_i[c] && (hot || rdy_i[c]);
  end

  assign in_ok_o   = (smp_i >= lo_i) && (smp_i <= hi_i);
  assign sb        = ~sel_i;
  assign a_ok      = vld_i[sel_i];
  assign s_ok      = vld_i[sb];
  assign s_tr      = trust[sb];
  assign mism      = res_i[sel_i] != res_i[sb];
  assign act_res_o = res_i[sel_i];

  // first indication: acceptance (valid) before comparison; mismatch blames active
  always_comb begin
    if (!a_ok && !s_ok && s_tr)  verdict_o = V_BOTH;
    else if (!a_ok)              verdict_o = V_SUSP_ACT;
    else if (s_tr && !s_ok)      verdict_o = V_SUSP_SB;
    else if (s_tr && mism)       verdict_o = V_SUSP_ACT;
    else                         verdict_o = V_OK;
  end
endmodule

// File: rtl/dfo_isolate.sv
module dfo_isolate
  import dup_failover_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fire_i,
  input  verdict_e       verdict_i,
  input  logic           confirm_i,
  input  logic           clear_i,
  input  logic           diag_done_i,
  input  logic           diag_pass_i,
  output logic           sel_o,
  output logic [NCH-1:0] fault_o,
  output logic           alarm_o,
  output logic           lost_o,
  output logic           diag_req_o,
  output logic           diag_ch_o,
  output logic           busy_o
);
  iso_state_e     state_q, state_n;
  logic           sel_q, sel_n;
  logic           susp_q, susp_n;
  logic [NCH-1:0] fault_q, fault_n;
  logic           alarm_q, alarm_n;
  logic           lost_q, lost_n;
  logic           blame_v, blame_c, dual;

  always_comb begin
    state_n = state_q;
    susp_n  = susp_q;
    blame_v = 1'b0;
    blame_c = susp_q;
    dual    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i && !alarm_q) begin
          if (verdict_i == V_BOTH) begin
            dual = 1'b1;
          end else if (verdict_i != V_OK) begin
            if (confirm_i) begin
              state_n = ST_DIAG1;
              susp_n  = (verdict_i == V_SUSP_ACT) ? sel_q : ~sel_q;
            end else begin
              blame_v = 1'b1;
              blame_c = (verdict_i == V_SUSP_ACT) ? sel_q : ~sel_q;
            end
          end
        end
      end
      ST_DIAG1: begin
        if (diag_done_i) begin
          if (!diag_pass_i) begin
            blame_v = 1'b1;
            state_n = ST_IDLE;
          end else if (fault_q[~susp_q]) begin
            dual    = 1'b1;
            state_n = ST_IDLE;
          end else begin
            state_n = ST_DIAG2;
            susp_n  = ~susp_q;
          end
        end
      end
      ST_DIAG2: begin
        if (diag_done_i) begin
          state_n = ST_IDLE;
          if (!diag_pass_i) blame_v = 1'b1;
          else              dual    = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    fault_n = fault_q;
    sel_n   = sel_q;
    alarm_n = alarm_q | dual;
    lost_n  = 1'b0;
    if (blame_v) begin
      fault_n[blame_c] = 1'b1;
      if (blame_c == sel_q) begin
        if (fault_q[~sel_q]) begin
          alarm_n = 1'b1;
        end else begin
          sel_n  = ~sel_q;
          lost_n = 1'b1;
        end
      end
    end
    if (clear_i) begin
      fault_n = '0;
      alarm_n = 1'b0;
      sel_n   = sel_q;
      lost_n  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      susp_q  <= 1'b0;
      fault_q <= '0;
      alarm_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= clear_i ? ST_IDLE : state_n;
      sel_q   <= sel_n;
      susp_q  <= susp_n;
      fault_q <= fault_n;
      alarm_q <= alarm_n;
      lost_q  <= lost_n;
    end
  end

  assign sel_o      = sel_q;
  assign fault_o    = fault_q;
  assign alarm_o    = alarm_q;
  assign lost_o     = lost_q;
  assign busy_o     = state_q != ST_IDLE;
  assign diag_req_o = state_q != ST_IDLE;
  assign diag_ch_o  = susp_q;

  AST_ACTIVE_HEALTHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_q |-> !fault_q[sel_q]); // R4
  AST_LOST_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |-> (sel_q != $past(sel_q))); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R11
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !clear_i) |=> alarm_q); // R10
  AST_ALARM_HOLDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |=> $stable(sel_q)); // R10
endmodule

// File: rtl/dfo_enable.sv
module dfo_enable
  import dup_failover_pkg::*;
(
  input  logic [1:0]     mode_i,
  input  logic           sel_i,
  input  logic [NCH-1:0] fault_i,
  input  logic           busy_i,
  output logic [NCH-1:0] en_o
);
  logic cold;
  assign cold = mode_i == MODE_COLD;

  for (genvar c = 0; c < NCH; c++) begin : g_en
    assign en_o[c] = (int'(sel_i) == c) || (!fault_i[c] && (!cold || busy_i));
  end
endmodule

// File: rtl/dup_failover.sv
module dup_failover
  import dup_failover_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         confirm_i,
  input  logic         clear_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] smp_i,
  input  logic         smp_vld_i,
  input  logic [W-1:0] res_a_i,
  input  logic         vld_a_i,
  input  logic         rdy_a_i,
  input  logic [W-1:0] res_b_i,
  input  logic         vld_b_i,
  input  logic         rdy_b_i,
  input  logic         diag_done_i,
  input  logic         diag_pass_i,
  output logic         en_a_o,
  output logic         en_b_o,
  output logic         diag_req_o,
  output logic         diag_ch_o,
  output logic [W-1:0] out_data_o,
  output logic         out_valid_o,
  output logic         sel_o,
  output logic         lost_o,
  output logic [1:0]   fault_o,
  output logic         alarm_o
);
  logic [NCH-1:0][W-1:0] res;
  logic [NCH-1:0]        vld, rdy, fault, en;
  logic                  in_ok, fire, sel, busy, alarm, fwd;
  verdict_e              verdict;
  logic [W-1:0]          act_res;
  logic [W-1:0]          dat_q;
  logic                  val_q;

  assign res = {res_b_i, res_a_i};
  assign vld = {vld_b_i, vld_a_i};
  assign rdy = {rdy_b_i, rdy_a_i};

  dfo_classify #(.W(W)) u_cls (
    .smp_i(smp_i), .lo_i(lo_i), .hi_i(hi_i), .res_i(res), .vld_i(vld),
    .rdy_i(rdy), .fault_i(fault), .sel_i(sel), .mode_i(mode_i),
    .in_ok_o(in_ok), .verdict_o(verdict), .act_res_o(act_res)
  );

  assign fire = smp_vld_i && in_ok;

  dfo_isolate u_iso (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .verdict_i(verdict),
    .confirm_i(confirm_i), .clear_i(clear_i), .diag_done_i(diag_done_i),
    .diag_pass_i(diag_pass_i), .sel_o(sel), .fault_o(fault), .alarm_o(alarm),
    .lost_o(lost_o), .diag_req_o(diag_req_o), .diag_ch_o(diag_ch_o), .busy_o(busy)
  );

  dfo_enable u_en (
    .mode_i(mode_i), .sel_i(sel), .fault_i(fault), .busy_i(busy), .en_o(en)
  );

  // forward only when the active result stands; standby-only fault without confirm still forwards
  assign fwd = fire && !busy && !alarm && !clear_i &&
               ((verdict == V_OK) || (verdict == V_SUSP_SB && !confirm_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      val_q <= 1'b0;
    end else begin
      val_q <= fwd;
      if (fwd) dat_q <= act_res;
    end
  end

  assign out_data_o  = dat_q;
  assign out_valid_o = val_q;
  assign sel_o       = sel;
  assign fault_o     = fault;
  assign alarm_o     = alarm;
  assign en_a_o      = en[0];
  assign en_b_o      = en[1];

  AST_DIAG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_req_o |-> !out_valid_o); // R12
  AST_LOST_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !out_valid_o); // R4
  AST_ALARM_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && $past(alarm_o)) |-> !out_valid_o); // R10
  AST_ACTIVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o ? en_b_o : en_a_o)); // R8
endmodule

// File: tb/dup_failover_test.sv
module dup_failover_test;
  localparam int CLK_P = 10;
  localparam logic [7:0] LO = 8'd3;
  localparam logic [7:0] HI = 8'd12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic confirm = 1'b0, clear = 1'b0;
  logic [7:0] smp = '0, res_a = '0, res_b = '0;
  logic smp_vld = 0, vld_a = 0, vld_b = 0, rdy_a = 0, rdy_b = 0;
  logic diag_done = 0, diag_pass = 0;
  logic en_a, en_b, diag_req, diag_ch, out_valid, sel, lost, alarm;
  logic [7:0] out_data;
  logic [1:0] fault;

  int total = 0, bad = 0;
  logic m_sel;
  logic [1:0] m_fault;
  logic m_alarm;

  always #(CLK_P/2) clk = ~clk;

  dup_failover #(.W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .confirm_i(confirm), .clear_i(clear),
    .lo_i(LO), .hi_i(HI), .smp_i(smp), .smp_vld_i(smp_vld),
    .res_a_i(res_a), .vld_a_i(vld_a), .rdy_a_i(rdy_a),
    .res_b_i(res_b), .vld_b_i(vld_b), .rdy_b_i(rdy_b),
    .diag_done_i(diag_done), .diag_pass_i(diag_pass),
    .en_a_o(en_a), .en_b_o(en_b), .diag_req_o(diag_req), .diag_ch_o(diag_ch),
    .out_data_o(out_data), .out_valid_o(out_valid), .sel_o(sel), .lost_o(lost),
    .fault_o(fault), .alarm_o(alarm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_vld = 0; clear = 0; diag_done = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    m_sel = 0; m_fault = 0; m_alarm = 0;
  endtask

  task automatic do_clear();
    smp_vld = 0; clear = 1;
    cyc();
    clear = 0;
    m_fault = 0; m_alarm = 0;
    chk("R11 clear fault", fault, 0);
    chk("R11 clear alarm", alarm, 0);
    chk("R11 clear keeps sel", sel, m_sel);
  endtask

  // confirmation off; expected state derived from the requirements
  task automatic do_sample(input logic [7:0] in, input logic [7:0] ra, input logic va,
                           input logic [7:0] rb, input logic vb, input logic ya,
                           input logic yb, input string tag);
    logic act, av, sv, sry, trust, ev, el, blame, bc;
    logic [7:0] ares, sres;
    smp = in; res_a = ra; vld_a = va; res_b = rb; vld_b = vb; rdy_a = ya; rdy_b = yb;
    smp_vld = 1;
    act = m_sel;
    ares = act ? rb : ra; sres = act ? ra : rb;
    av = act ? vb : va;   sv = act ? va : vb;
    sry = act ? ya : yb;
    trust = !m_fault[~act] && (mode == 2'b00 || mode == 2'b11 || sry);
    ev = 0; el = 0; blame = 0; bc = act;
    if (in >= LO && in <= HI && !m_alarm) begin
      if (!av && !sv && trust) m_alarm = 1;
      else if (!av) begin blame = 1; bc = act; end
      else if (trust && !sv) begin blame = 1; bc = ~act; ev = 1; end
      else if (trust && ares != sres) begin blame = 1; bc = act; end
      else ev = 1;
    end
    if (blame) begin
      m_fault[bc] = 1;
      if (bc == act) begin
        if (m_fault[~act]) m_alarm = 1;
        else begin m_sel = ~act; el = 1; end
      end
    end
    cyc();
    smp_vld = 0;
    chk(tag, out_valid, ev);
    if (ev) chk("R2 data", out_data, ares);
    chk("R4 lost", lost, el);
    chk("R5 sel", sel, m_sel);
    chk("R11 fault", fault, m_fault);
    chk("R10 alarm", alarm, m_alarm);
    chk("R8 en_a", en_a, (m_sel == 0) || (!m_fault[0] && mode != 2'b10));
    chk("R8 en_b", en_b, (m_sel == 1) || (!m_fault[1] && mode != 2'b10));
  endtask

  task automatic diag_step(input logic pass);
    diag_done = 1; diag_pass = pass;
    cyc();
    diag_done = 0;
  endtask

  task automatic mismatch_sample();
    smp = 8'd5; res_a = 8'd10; res_b = 8'd11; vld_a = 1; vld_b = 1; rdy_a = 1; rdy_b = 1;
    smp_vld = 1;
    cyc();
    smp_vld = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    chk("R1 sel", sel, 0);
    chk("R1 fault", fault, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 lost", lost, 0);
    chk("R1 diag_req", diag_req, 0);

    // R2 normal forwarding, R3 range edges
    do_sample(LO, 8'h21, 1, 8'h21, 1, 1, 1, "R2 valid lo edge");
    do_sample(HI, 8'h42, 1, 8'h42, 1, 1, 1, "R2 valid hi edge");
    do_sample(LO - 8'd1, 8'h1, 0, 8'h2, 1, 1, 1, "R3 below range");
    do_sample(HI + 8'd1, 8'h1, 1, 8'h2, 0, 1, 1, "R3 above range");

    // R6 trusted standby invalid
    do_sample(8'd6, 8'h33, 1, 8'h00, 0, 1, 1, "R6 standby invalid forwards");
    do_clear();

    // R4/R5 A->B then B->A
    do_sample(8'd7, 8'h10, 0, 8'h10, 1, 1, 1, "R4 active invalid");
    do_clear();
    do_sample(8'd7, 8'h10, 1, 8'h11, 1, 1, 1, "R5 back to A");

    // R7 warm untrusted standby ignored, reserved mode trusted
    mode = 2'b01; do_clear();
    do_sample(8'd8, 8'h55, 1, 8'h56, 0, 0, 0, "R7 warm untrusted");
    do_sample(8'd8, 8'h55, 1, 8'h56, 1, 1, 1, "R7 warm trusted mismatch");
    mode = 2'b11; do_clear();
    do_sample(8'd8, 8'h55, 1, 8'h57, 1, 0, 0, "R7 reserved as hot");

    // R10 both invalid, then muted
    mode = 2'b00; do_clear();
    do_sample(8'd9, 8'h1, 0, 8'h1, 0, 1, 1, "R10 both invalid");
    do_sample(8'd9, 8'h1, 1, 8'h1, 1, 1, 1, "R10 muted while alarmed");
    do_clear();

    // sweep every mode with pseudo-random patterns
    r = 32'h1234_5678;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      do_clear();
      for (int i = 0; i < 160; i++) begin
        logic [7:0] ra;
        r = r * 32'd1664525 + 32'd1013904223;
        ra = r[23:16];
        do_sample({4'h0, r[3:0]}, ra, r[6:4] != 0, (r[12:10] == 0) ? ra ^ 8'h1 : ra,
                  r[9:7] != 0, r[13], r[14], "R2 sweep valid");
        if (i % 20 == 19) do_clear();
      end
    end

    // R9/R12 confirm: suspect active fails diagnostic
    mode = 2'b00; confirm = 1; do_reset();
    mismatch_sample();
    chk("R9 no output on suspect", out_valid, 0);
    chk("R9 diag_req", diag_req, 1);
    chk("R9 diag_ch active", diag_ch, 0);
    smp = 8'd5; res_a = 8'd9; res_b = 8'd9; smp_vld = 1;
    cyc(); smp_vld = 0;
    chk("R12 sample during diag", out_valid, 0);
    chk("R12 fault untouched", fault, 0);
    diag_step(0);
    chk("R9 fault A", fault, 2'b01);
    chk("R9 switched", sel, 1);
    chk("R9 lost", lost, 1);
    chk("R9 diag done", diag_req, 0);
    cyc();
    chk("R4 lost one cycle", lost, 0);

    // R9 suspect passes, other fails
    do_reset();
    mismatch_sample();
    diag_step(1);
    chk("R9 second diag req", diag_req, 1);
    chk("R9 second diag ch", diag_ch, 1);
    diag_step(0);
    chk("R9 fault B", fault, 2'b10);
    chk("R9 sel kept", sel, 0);
    chk("R9 no lost", lost, 0);

    // R10 both diagnostics pass
    do_reset();
    mismatch_sample();
    diag_step(1);
    diag_step(1);
    chk("R10 dual alarm", alarm, 1);
    chk("R10 sel held", sel, 0);
    chk("R10 no marks", fault, 0);
    smp = 8'd5; res_a = 8'd4; res_b = 8'd4; smp_vld = 1;
    cyc(); smp_vld = 0;
    chk("R10 muted", out_valid, 0);
    clear = 1; cyc(); clear = 0;
    chk("R11 alarm cleared", alarm, 0);

    // R8 cold: standby wakes during isolation
    mode = 2'b10; do_reset();
    chk("R8 cold standby off", en_b, 0);
    chk("R8 cold active on", en_a, 1);
    mismatch_sample();
    chk("R8 cold standby woken", en_b, 1);
    diag_step(0);
    chk("R8 new active on", en_b, 1);
    chk("R8 faulty off", en_a, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule